// File: doc/BRIEF.md
# Dual-Channel Memory Address Mapper

This block sits between a request source and two memory channels, each with a 64-bit data path. It takes a physical byte address with a read/write flag and a per-byte write mask, and decides which channel serves the request and what address that channel sees. Every request moves one 64-byte line, which each channel delivers as a burst of eight 8-byte beats.

There are three mappings, chosen at run time. In single mode every request goes to channel A. In stacked mode the two channels form one linear space: channel A is filled first, and channel B starts right after channel A's last byte, so unequal capacities are supported. In interleaved mode consecutive 64-byte lines alternate between channels. A request outside populated memory is never forwarded. It is accepted at once and flagged as an error to the requester.

The datapath is combinational from request to channel, so an accepted request reaches its channel in the cycle it is accepted. The only state is a snapshot of the configuration, which is refreshed only while no request is waiting.

Top module: `chan_addr_mapper`

## Requirements
- R1: With mode code 0 (single), every in-range request goes to channel A with its address unchanged, and `b_valid_o` stays low.
- R2: With mode code 1 (stacked), an address below capacity A goes to channel A unchanged. An address at or above it goes to channel B with local address equal to the address minus capacity A.
- R3: With mode code 2 (interleaved), address bit 6 selects the channel (0 = A, 1 = B). The local address is the request address with bit 6 removed, the upper bits shifted down by one and a zero placed in the top bit.
- R4: The populated limit is capacity A in single mode, A+B in stacked mode and twice the smaller capacity in interleaved mode. A valid request at or above the limit raises `req_err_o` and `req_ready_o` in the same cycle, and neither channel valid is raised.
- R5: A valid in-range request raises the valid of exactly one channel. `req_ready_o` then equals that channel's ready, and the valid of the other channel stays low.
- R6: The write flag and the 64-bit byte mask reach the selected channel unchanged.
- R7: Configuration inputs are sampled only at a clock edge where `req_valid_i` is low, and they take effect from the next cycle. Changes made while a request is held are ignored until the requester goes idle.
- R8: Mode code 3 behaves exactly as single mode.
- R9: A request is forwarded in the cycle in which it is presented, with no buffering, so requests reach each channel in their arrival order.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| cfg_mode_i | input | 2 | Mapping mode: 0 single, 1 stacked, 2 interleaved, 3 single |
| cfg_cap_a_i | input | ADDR_W+1 | Channel A capacity in bytes |
| cfg_cap_b_i | input | ADDR_W+1 | Channel B capacity in bytes |
| req_valid_i | input | 1 | Request valid |
| req_ready_o | output | 1 | Request accepted |
| req_err_o | output | 1 | Request falls outside populated memory |
| req_addr_i | input | ADDR_W | Request byte address |
| req_we_i | input | 1 | Write flag |
| req_mask_i | input | MASK_W | Per-byte write mask |
| a_valid_o | output | 1 | Channel A request valid |
| a_ready_i | input | 1 | Channel A ready |
| a_addr_o | output | ADDR_W | Channel A local address |
| a_we_o | output | 1 | Channel A write flag |
| a_mask_o | output | MASK_W | Channel A byte mask |
| b_valid_o | output | 1 | Channel B request valid |
| b_ready_i | input | 1 | Channel B ready |
| b_addr_o | output | ADDR_W | Channel B local address |
| b_we_o | output | 1 | Channel B write flag |
| b_mask_o | output | MASK_W | Channel B byte mask |

## Verification
The bench builds the mapper with `ADDR_W` = 10, a 1 KB space, and keeps the 64-byte line and 64-bit mask. This makes it practical to send every byte address through each of eight configurations. The configurations cover both single-mode codes, stacked layouts with unequal capacities and with the full sum at the top of the space, and interleaving with both equal and unequal capacities. Each address is presented once with both channels ready and once with the selected channel stalled, so every limit boundary and every channel switch point is checked. A separate sequence changes the configuration while a request is stalled, then checks that the change is ignored while the request is held and applied once the requester is idle.

// File: rtl/chan_map_pkg.sv
package chan_map_pkg;
  typedef enum logic [1:0] {
    MAP_SINGLE = 2'd0,
    MAP_STACK  = 2'd1,
    MAP_ILV    = 2'd2,
    MAP_RSVD   = 2'd3
  } map_mode_e;

  localparam int unsigned NUM_CH = 2;
endpackage

// File: rtl/cfg_hold.sv
module cfg_hold
  import chan_map_pkg::*;
#(
  parameter int unsigned CAP_W = 33
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             busy_i,
  input  logic [1:0]       mode_i,
  input  logic [CAP_W-1:0] cap_a_i,
  input  logic [CAP_W-1:0] cap_b_i,
  output map_mode_e        mode_o,
  output logic [CAP_W-1:0] cap_a_o,
  output logic [CAP_W-1:0] cap_b_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      mode_o  <= MAP_SINGLE;
      cap_a_o <= '0;
      cap_b_o <= '0;
    end else if (!busy_i) begin
      mode_o  <= map_mode_e'(mode_i);
      cap_a_o <= cap_a_i;
      cap_b_o <= cap_b_i;
    end
  end

  p_cfg_frozen_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy_i |=> ($stable(mode_o) && $stable(cap_a_o) && $stable(cap_b_o)));
endmodule

// File: rtl/addr_decode.sv
module addr_decode
  import chan_map_pkg::*;
#(
  parameter int unsigned ADDR_W   = 32,
  parameter int unsigned LINE_BIT = 6
) (
  input  map_mode_e         mode_i,
  input  logic [ADDR_W:0]   cap_a_i,
  input  logic [ADDR_W:0]   cap_b_i,
  input  logic [ADDR_W-1:0] addr_i,
  output logic              sel_o,
  output logic              err_o,
  output logic [ADDR_W-1:0] local_o
);
  localparam int unsigned LIM_W = ADDR_W + 2;

  logic [LIM_W-1:0] addr_x, cap_a_x, cap_b_x, min_x, limit;

  always_comb begin
    addr_x  = LIM_W'(addr_i);
    cap_a_x = LIM_W'(cap_a_i);
    cap_b_x = LIM_W'(cap_b_i);
    min_x   = (cap_a_x < cap_b_x) ? cap_a_x : cap_b_x;
    sel_o   = 1'b0;
    local_o = addr_i;
    limit   = cap_a_x;
    case (mode_i)
      MAP_STACK: begin
        limit = cap_a_x + cap_b_x;
        if (addr_x >= cap_a_x) begin
          sel_o   = 1'b1;
          local_o = ADDR_W'(addr_x - cap_a_x);
        end
      end
      MAP_ILV: begin
        limit   = min_x << 1;
        sel_o   = addr_i[LINE_BIT];
        // drop the channel bit, close the gap
        local_o = {1'b0, addr_i[ADDR_W-1:LINE_BIT+1], addr_i[LINE_BIT-1:0]};
      end
      default: ;
    endcase
    err_o = addr_x >= limit;
  end
endmodule

// File: rtl/chan_route.sv
module chan_route #(
  parameter int unsigned ADDR_W = 32,
  parameter int unsigned MASK_W = 64,
  parameter bit          CH_ID  = 1'b0
) (
  input  logic              req_valid_i,
  input  logic              sel_i,
  input  logic              err_i,
  input  logic [ADDR_W-1:0] local_i,
  input  logic              we_i,
  input  logic [MASK_W-1:0] mask_i,
  input  logic              ready_i,
  output logic              valid_o,
  output logic              hit_ready_o,
  output logic [ADDR_W-1:0] addr_o,
  output logic              we_o,
  output logic [MASK_W-1:0] mask_o
);
  logic hit;
  assign hit         = !err_i && (sel_i == CH_ID);
  assign valid_o     = req_valid_i && hit;
  assign hit_ready_o = hit && ready_i;
  assign addr_o      = local_i;
  assign we_o        = we_i;
  assign mask_o      = mask_i;
endmodule

// File: rtl/chan_addr_mapper.sv
module chan_addr_mapper
  import chan_map_pkg::*;
#(
  parameter int unsigned ADDR_W     = 32,
  parameter int unsigned LINE_BYTES = 64,
  localparam int unsigned LINE_BIT  = $clog2(LINE_BYTES),
  localparam int unsigned MASK_W    = LINE_BYTES,
  localparam int unsigned CAP_W     = ADDR_W + 1
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [1:0]        cfg_mode_i,
  input  logic [CAP_W-1:0]  cfg_cap_a_i,
  input  logic [CAP_W-1:0]  cfg_cap_b_i,
  input  logic              req_valid_i,
  output logic              req_ready_o,
  output logic              req_err_o,
  input  logic [ADDR_W-1:0] req_addr_i,
  input  logic              req_we_i,
  input  logic [MASK_W-1:0] req_mask_i,
  output logic              a_valid_o,
  input  logic              a_ready_i,
  output logic [ADDR_W-1:0] a_addr_o,
  output logic              a_we_o,
  output logic [MASK_W-1:0] a_mask_o,
  output logic              b_valid_o,
  input  logic              b_ready_i,
  output logic [ADDR_W-1:0] b_addr_o,
  output logic              b_we_o,
  output logic [MASK_W-1:0] b_mask_o
);
  map_mode_e         mode_q;
  logic [CAP_W-1:0]  cap_a_q, cap_b_q;
  logic              sel, err;
  logic [ADDR_W-1:0] local_addr;

  cfg_hold #(.CAP_W(CAP_W)) u_cfg (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .busy_i  (req_valid_i),
    .mode_i  (cfg_mode_i),
    .cap_a_i (cfg_cap_a_i),
    .cap_b_i (cfg_cap_b_i),
    .mode_o  (mode_q),
    .cap_a_o (cap_a_q),
    .cap_b_o (cap_b_q)
  );

  addr_decode #(.ADDR_W(ADDR_W), .LINE_BIT(LINE_BIT)) u_dec (
    .mode_i  (mode_q),
    .cap_a_i (cap_a_q),
    .cap_b_i (cap_b_q),
    .addr_i  (req_addr_i),
    .sel_o   (sel),
    .err_o   (err),
    .local_o (local_addr)
  );

  logic [NUM_CH-1:0]             ch_valid, ch_ready, ch_hit_rdy, ch_we;
  logic [NUM_CH-1:0][ADDR_W-1:0] ch_addr;
  logic [NUM_CH-1:0][MASK_W-1:0] ch_mask;

  assign ch_ready = {b_ready_i, a_ready_i};

  for (genvar c = 0; c < NUM_CH; c++) begin : g_ch
    chan_route #(.ADDR_W(ADDR_W), .MASK_W(MASK_W), .CH_ID(c[0])) u_route (
      .req_valid_i (req_valid_i),
      .sel_i       (sel),
      .err_i       (err),
      .local_i     (local_addr),
      .we_i        (req_we_i),
      .mask_i      (req_mask_i),
      .ready_i     (ch_ready[c]),
      .valid_o     (ch_valid[c]),
      .hit_ready_o (ch_hit_rdy[c]),
      .addr_o      (ch_addr[c]),
      .we_o        (ch_we[c]),
      .mask_o      (ch_mask[c])
    );
  end

  assign req_err_o   = req_valid_i && err;
  assign req_ready_o = err || (|ch_hit_rdy);

  assign a_valid_o = ch_valid[0];
  assign a_addr_o  = ch_addr[0];
  assign a_we_o    = ch_we[0];
  assign a_mask_o  = ch_mask[0];
  assign b_valid_o = ch_valid[1];
  assign b_addr_o  = ch_addr[1];
  assign b_we_o    = ch_we[1];
  assign b_mask_o  = ch_mask[1];

  p_one_chan_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0({a_valid_o, b_valid_o, req_err_o}));
  p_err_no_fwd_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    req_err_o |-> (req_ready_o && !a_valid_o && !b_valid_o));
  p_single_a_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mode_q == MAP_SINGLE || mode_q == MAP_RSVD) |-> !b_valid_o);
  p_ready_a_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    a_valid_o |-> (req_ready_o == a_ready_i));
  p_ready_b_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    b_valid_o |-> (req_ready_o == b_ready_i));
  p_fwd_now_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_valid_i && !req_err_o) |-> (a_valid_o || b_valid_o));
endmodule

// File: tb/chan_addr_mapper_test.sv
`timescale 1ns/1ps
module chan_addr_mapper_test;
  localparam int AW = 10;
  localparam int MW = 64;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic [1:0]    cfg_mode = 2'd0;
  logic [AW:0]   cap_a = '0, cap_b = '0;
  logic          req_valid = 1'b0, req_we = 1'b0;
  logic [AW-1:0] req_addr = '0;
  logic [MW-1:0] req_mask = '0;
  logic          a_ready = 1'b1, b_ready = 1'b1;
  logic          req_ready, req_err, a_valid, b_valid, a_we, b_we;
  logic [AW-1:0] a_addr, b_addr;
  logic [MW-1:0] a_mask, b_mask;

  int n_chk = 0, n_fail = 0, cycles = 0;

  always #4 clk = ~clk;

  chan_addr_mapper #(.ADDR_W(AW), .LINE_BYTES(64)) uut (
    .clk_i(clk), .rst_ni(rst_n),
    .cfg_mode_i(cfg_mode), .cfg_cap_a_i(cap_a), .cfg_cap_b_i(cap_b),
    .req_valid_i(req_valid), .req_ready_o(req_ready), .req_err_o(req_err),
    .req_addr_i(req_addr), .req_we_i(req_we), .req_mask_i(req_mask),
    .a_valid_o(a_valid), .a_ready_i(a_ready), .a_addr_o(a_addr),
    .a_we_o(a_we), .a_mask_o(a_mask),
    .b_valid_o(b_valid), .b_ready_i(b_ready), .b_addr_o(b_addr),
    .b_we_o(b_we), .b_mask_o(b_mask)
  );

  task automatic check(input bit ok, input string tag, input longint act, input longint exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic summary();
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles > 150000) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog actual=%0d expected=%0d", cycles, 150000);
      summary();
    end
  end

  task automatic set_cfg(input int m, input int ca, input int cb);
    @(negedge clk);
    req_valid = 1'b0;
    cfg_mode = m[1:0]; cap_a = ca[AW:0]; cap_b = cb[AW:0];
    @(posedge clk); @(negedge clk);
  endtask

  // expected mapping: ch 0=A 1=B, err when out of range
  task automatic model(input int m, input int ca, input int cb, input int ad,
                       output bit ch, output bit er, output int loc);
    int lim;
    ch = 0; loc = ad;
    case (m)
      1: begin lim = ca + cb; if (ad >= ca) begin ch = 1; loc = ad - ca; end end
      2: begin
        lim = 2 * ((ca < cb) ? ca : cb);
        ch  = ad[6];
        loc = ((ad >> 7) << 6) | (ad & 63);
      end
      default: lim = ca;
    endcase
    er = ad >= lim;
  endtask

  task automatic sweep(input int m, input int ca, input int cb, input string tag);
    bit ch, er; int loc;
    set_cfg(m, ca, cb);
    for (int ad = 0; ad < (1 << AW); ad++) begin
      model(m, ca, cb, ad, ch, er, loc);
      req_addr  = ad[AW-1:0];
      req_we    = ad[0] ^ ad[3];
      req_mask  = {ad[7:0], ~ad[7:0], ad[9:0], 38'h2a5a5a5a5a} ^ MW'(ad * 64'h9e3779b97f4a7c15);
      req_valid = 1'b1;
      a_ready = 1'b1; b_ready = 1'b1;
      #1;
      if (er) begin
        check(req_err && req_ready && !a_valid && !b_valid, $sformatf("R4 %s ad=%0d", tag, ad),
              {req_err, req_ready, a_valid, b_valid}, 4'b1100);
      end else if (!ch) begin
        check(!req_err && req_ready && a_valid && !b_valid && a_addr == loc[AW-1:0]
              && a_we == req_we && a_mask == req_mask,
              $sformatf("%s R5 R6 R9 ch=A ad=%0d", tag, ad), a_addr, loc);
      end else begin
        check(!req_err && req_ready && b_valid && !a_valid && b_addr == loc[AW-1:0]
              && b_we == req_we && b_mask == req_mask,
              $sformatf("%s R5 R6 R9 ch=B ad=%0d", tag, ad), b_addr, loc);
      end
      // stall the selected channel; R5
      if (ch) b_ready = 1'b0; else a_ready = 1'b0;
      #1;
      check(req_ready == er, $sformatf("R5 stall %s ad=%0d", tag, ad), req_ready, er);
      a_ready = 1'b1; b_ready = 1'b1;
    end
    req_valid = 1'b0;
  endtask

  initial begin
    #2;
    check(!a_valid && !b_valid && !req_err, "reset idle outputs", {a_valid, b_valid, req_err}, 0);
    #20 rst_n = 1'b1;

    sweep(0, 1024, 0,   "R1 single full");
    sweep(0, 512,  512, "R1 single half");
    sweep(1, 512,  256, "R2 stack unequal");
    sweep(1, 384,  640, "R2 stack full");
    sweep(1, 1024, 0,   "R2 stack A only");
    sweep(2, 512,  512, "R3 ilv equal");
    sweep(2, 512,  256, "R3 ilv unequal");
    sweep(3, 640,  384, "R8 mode3");

    // R7: cfg change while a request is held
    set_cfg(1, 512, 512);
    req_addr = 10'd600; req_valid = 1'b1; b_ready = 1'b0;
    #1;
    check(b_valid && b_addr == 10'd88 && !req_ready, "R7 stalled on B", b_addr, 88);
    cfg_mode = 2'd0; cap_a = 11'd1024; cap_b = 11'd0;
    @(posedge clk); @(negedge clk);
    check(b_valid && !a_valid && b_addr == 10'd88, "R7 change ignored while held", b_addr, 88);
    @(posedge clk); @(negedge clk);
    check(b_valid && !a_valid, "R7 still ignored", b_valid, 1);
    b_ready = 1'b1;
    #1;
    check(req_ready, "R7 accepted on old cfg", req_ready, 1);
    @(negedge clk);
    req_valid = 1'b0;
    @(posedge clk); @(negedge clk);
    req_valid = 1'b1;
    #1;
    check(a_valid && !b_valid && a_addr == 10'd600, "R7 applied after idle", a_addr, 600);
    req_valid = 1'b0;
    @(negedge clk);
    summary();
  end
endmodule